// File: doc/BRIEF.md
# Shared Memory Port Arbiter for a Five-Stage Pipeline

This block sits between a five-stage in-order pipeline (fetch, decode and register read, execute, memory, write-back) and one single-ported memory. Instruction fetch and the data access of the memory stage both need that port, and it can serve only one of them per clock. The block picks the user of the port in each cycle, holds the program counter and the fetch-to-decode register when fetch loses, and sends a no-op down the pipe in the slot the lost fetch would have filled.

The memory is outside the block and is modelled as a synchronous-read RAM: the read data of a granted access is present on `mem_rdata` one cycle after the request. The block owns the program counter, the fetch-to-decode register and the word handed to the decode-to-execute register. A free-running counter reports how many fetch cycles were lost to conflicts.

Top module: `shared_port_hazard_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it drops, `pc` is RESET_PC (default 0), `ifid_valid`, `bubble` and `data_rvalid` are 0, `stall_count` is 0 and `idex_instr` is NOP_WORD (default 0).
- R2: In a cycle where `data_req` is 1, the port carries the data access in that same cycle: `mem_en`=1, `mem_we`=`data_we`, `mem_addr`=`data_addr`, `mem_wdata`=`data_wdata`; after a read, `data_rvalid` is 1 in the next cycle and `data_rdata` shows the addressed word.
- R3: In a cycle where `fetch_req` is 1 and `data_req` is 0, the port performs a read (`mem_en`=1, `mem_we`=0) at `mem_addr`=`pc`, and `pc` is larger by 4 in the next cycle.
- R4: When both requests are present, the data access owns the port, `stall` is 1 in that cycle, and `pc` is unchanged in the next cycle.
- R5: A word fetched in cycle t from address P appears two cycles later as `ifid_instr` with `ifid_pc`=P and `ifid_valid`=1, and `idex_instr` equals that word in the same cycle.
- R6: A conflict in cycle t makes `bubble`=1 in cycle t+2; in that cycle `idex_instr` is NOP_WORD and `ifid_pc`/`ifid_instr` keep their previous values.
- R7: Each conflict cycle costs exactly one lost fetch: `stall_count` rises by one per conflict cycle and is unchanged otherwise, so after N fetch-requesting cycles with K conflicts `pc` has advanced by 4*(N-K).
- R8: With neither request present, `mem_en` is 0, `stall` is 0 and `pc` is unchanged in the next cycle.
- R9: A store (`data_req`=1, `data_we`=1) is never followed by `data_rvalid`=1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch stage wants the port this cycle |
| data_req | input | 1 | Memory stage holds a load or store this cycle |
| data_we | input | 1 | 1 for store, 0 for load |
| data_addr | input | 32 | Byte address of the memory-stage access |
| data_wdata | input | 32 | Store data |
| data_rdata | output | 32 | Load result, valid with `data_rvalid` |
| data_rvalid | output | 1 | Load result present this cycle |
| mem_en | output | 1 | Shared port enable |
| mem_we | output | 1 | Shared port write enable |
| mem_addr | output | 32 | Shared port byte address |
| mem_wdata | output | 32 | Shared port write data |
| mem_rdata | input | 32 | Shared port read data, one cycle after the request |
| pc | output | 32 | Program counter of the next fetch |
| stall | output | 1 | Fetch blocked by a data access this cycle |
| ifid_valid | output | 1 | Fetch-to-decode register holds an instruction |
| ifid_pc | output | 32 | Address of the instruction in the fetch-to-decode register |
| ifid_instr | output | 32 | Instruction in the fetch-to-decode register |
| bubble | output | 1 | This slot carries a no-op caused by a conflict |
| idex_instr | output | 32 | Word handed to the decode-to-execute register |
| stall_count | output | 16 | Number of conflict cycles since reset |

## Verification
The bench sweeps every four-cycle sequence of fetch, load, store and idle, so back-to-back conflicts, a conflict right after a granted fetch and a store between fetches all occur. A design that let fetch win would put the fetch address on the port during a load and corrupt the data result; one that advanced the PC on a conflict would skip an instruction, which the PC and fetch-address checks catch. A design that delayed the bubble by the wrong number of cycles, or reissued the held instruction instead of a no-op, would show the old word on `idex_instr` in the slot where the bench expects NOP_WORD, and a counter that missed or double-counted conflicts would drift away from the bench's running total.

// File: rtl/smha_pkg.sv
package smha_pkg;

  typedef enum logic [1:0] {
    OWNER_IDLE  = 2'd0,
    OWNER_FETCH = 2'd1,
    OWNER_DATA  = 2'd2
  } port_owner_e;

endpackage

// File: rtl/smha_arbiter.sv
module smha_arbiter
  import smha_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          fetch_req,
  input  logic          data_req,
  input  logic          data_we,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] data_addr,
  input  logic [DW-1:0] data_wdata,
  output port_owner_e   owner,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          fetch_grant,
  output logic          data_grant,
  output logic          conflict
);

  // The memory stage is older in program order, so it always wins.
  always_comb begin
    if (data_req)       owner = OWNER_DATA;
    else if (fetch_req) owner = OWNER_FETCH;
    else                owner = OWNER_IDLE;
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = fetch_addr;
    mem_wdata = '0;
    unique case (owner)
      OWNER_DATA: begin
        mem_en    = 1'b1;
        mem_we    = data_we;
        mem_addr  = data_addr;
        mem_wdata = data_wdata;
      end
      OWNER_FETCH: begin
        mem_en   = 1'b1;
        mem_addr = fetch_addr;
      end
      default: ;
    endcase
  end

  assign data_grant  = (owner == OWNER_DATA);
  assign fetch_grant = (owner == OWNER_FETCH);
  assign conflict    = fetch_req && data_req;

endmodule

// File: rtl/smha_fetch_unit.sv
module smha_fetch_unit #(
  parameter int              AW       = 32,
  parameter int              DW       = 32,
  parameter int              PC_STEP  = 4,
  parameter logic [AW-1:0]   RESET_PC = '0,
  parameter logic [DW-1:0]   NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fetch_grant,
  input  logic          conflict,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc,
  output logic          ifid_valid,
  output logic [AW-1:0] ifid_pc,
  output logic [DW-1:0] ifid_instr,
  output logic          bubble,
  output logic [DW-1:0] idex_instr
);

  localparam logic [AW-1:0] STEP = AW'(PC_STEP);

  logic          fetch_pend;
  logic [AW-1:0] fetch_pend_pc;
  logic          bubble_pend;
  logic          ifid_new;

  // Request stage: PC and the record of what is in flight at the port.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc            <= RESET_PC;
      fetch_pend    <= 1'b0;
      fetch_pend_pc <= RESET_PC;
      bubble_pend   <= 1'b0;
    end else begin
      if (fetch_grant) pc <= pc + STEP;
      fetch_pend    <= fetch_grant;
      fetch_pend_pc <= pc;
      bubble_pend   <= conflict;
    end
  end

  // Return stage: the fetch-to-decode register loads only on returned fetch data.
  always_ff @(posedge clk) begin
    if (rst) begin
      ifid_valid <= 1'b0;
      ifid_pc    <= RESET_PC;
      ifid_instr <= NOP_WORD;
      ifid_new   <= 1'b0;
      bubble     <= 1'b0;
    end else begin
      if (fetch_pend) begin
        ifid_valid <= 1'b1;
        ifid_pc    <= fetch_pend_pc;
        ifid_instr <= mem_rdata;
      end
      ifid_new <= fetch_pend;
      bubble   <= bubble_pend;
    end
  end

  assign idex_instr = ifid_new ? ifid_instr : NOP_WORD;

  AST_PC_HOLD_ON_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    conflict |=> pc == $past(pc)); // R4

  AST_PC_STEP_ON_FETCH: assert property (@(posedge clk) disable iff (rst)
    fetch_grant |=> pc == $past(pc) + STEP); // R3

  AST_BUBBLE_NOT_FRESH: assert property (@(posedge clk) disable iff (rst)
    bubble |-> !ifid_new); // R6

  AST_BUBBLE_HOLDS_IFID: assert property (@(posedge clk) disable iff (rst)
    bubble |-> $stable(ifid_instr) && $stable(ifid_pc)); // R6

endmodule

// File: rtl/smha_stall_counter.sv
module smha_stall_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= count + ONE;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    inc |=> count == $past(count) + ONE); // R7

  AST_CNT_STILL: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count)); // R7

endmodule

// File: rtl/shared_port_hazard_unit.sv
module shared_port_hazard_unit
  import smha_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter int            CNT_W    = 16,
  parameter logic [31:0]   RESET_PC = 32'h0,
  parameter logic [31:0]   NOP_WORD = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_req,
  input  logic             data_req,
  input  logic             data_we,
  input  logic [AW-1:0]    data_addr,
  input  logic [DW-1:0]    data_wdata,
  output logic [DW-1:0]    data_rdata,
  output logic             data_rvalid,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    pc,
  output logic             stall,
  output logic             ifid_valid,
  output logic [AW-1:0]    ifid_pc,
  output logic [DW-1:0]    ifid_instr,
  output logic             bubble,
  output logic [DW-1:0]    idex_instr,
  output logic [CNT_W-1:0] stall_count
);

  port_owner_e owner;
  logic        fetch_grant;
  logic        data_grant;
  logic        conflict;

  smha_arbiter #(.AW(AW), .DW(DW)) u_arb (
    .fetch_req   (fetch_req),
    .data_req    (data_req),
    .data_we     (data_we),
    .fetch_addr  (pc),
    .data_addr   (data_addr),
    .data_wdata  (data_wdata),
    .owner       (owner),
    .mem_en      (mem_en),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .fetch_grant (fetch_grant),
    .data_grant  (data_grant),
    .conflict    (conflict)
  );

  smha_fetch_unit #(
    .AW(AW), .DW(DW), .PC_STEP(4),
    .RESET_PC(AW'(RESET_PC)), .NOP_WORD(DW'(NOP_WORD))
  ) u_fetch (
    .clk         (clk),
    .rst         (rst),
    .fetch_grant (fetch_grant),
    .conflict    (conflict),
    .mem_rdata   (mem_rdata),
    .pc          (pc),
    .ifid_valid  (ifid_valid),
    .ifid_pc     (ifid_pc),
    .ifid_instr  (ifid_instr),
    .bubble      (bubble),
    .idex_instr  (idex_instr)
  );

  smha_stall_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (conflict),
    .count (stall_count)
  );

  always_ff @(posedge clk) begin
    if (rst) data_rvalid <= 1'b0;
    else     data_rvalid <= data_grant && !data_we;
  end

  assign data_rdata = mem_rdata;
  assign stall      = conflict;

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fetch_grant, data_grant})); // R4

  AST_DATA_ON_PORT: assert property (@(posedge clk) disable iff (rst)
    data_req |-> mem_en && mem_addr == data_addr && mem_we == data_we); // R2

  AST_IDLE_PORT: assert property (@(posedge clk) disable iff (rst)
    (!fetch_req && !data_req) |-> !mem_en && !stall); // R8

  AST_STORE_NO_RVALID: assert property (@(posedge clk) disable iff (rst)
    (data_req && data_we) |=> !data_rvalid); // R9

endmodule

// File: tb/tb_shared_port_hazard_unit.sv
module tb_shared_port_hazard_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_req = 1'b0, data_req = 1'b0, data_we = 1'b0;
  logic [31:0] data_addr = '0, data_wdata = '0;
  logic [31:0] data_rdata, mem_addr, mem_wdata, pc, ifid_pc, ifid_instr, idex_instr;
  logic [31:0] mem_rdata = '0;
  logic        data_rvalid, mem_en, mem_we, stall, ifid_valid, bubble;
  logic [15:0] stall_count;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shared_port_hazard_unit dut (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .data_req(data_req), .data_we(data_we),
    .data_addr(data_addr), .data_wdata(data_wdata), .data_rdata(data_rdata),
    .data_rvalid(data_rvalid), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc(pc), .stall(stall),
    .ifid_valid(ifid_valid), .ifid_pc(ifid_pc), .ifid_instr(ifid_instr), .bubble(bubble),
    .idex_instr(idex_instr), .stall_count(stall_count)
  );

  // Single-port synchronous-read memory model.
  logic [31:0] tmem [0:63];
  initial for (int i = 0; i < 64; i++) tmem[i] = 32'hC0DE_0000 | i;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) tmem[mem_addr[7:2]] <= mem_wdata;
      else        mem_rdata <= tmem[mem_addr[7:2]];
    end
  end

  // Expected state, derived from the requirements.
  logic [31:0] e_pc = 0, e_fpc = 0, e_fword = 0, e_dword = 0;
  logic [31:0] e_ifid_pc = 0, e_ifid_instr = 0;
  logic        e_fpend = 0, e_bpend = 0, e_new = 0, e_bub = 0, e_valid = 0, e_rvalid = 0;
  logic [15:0] e_cnt = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic f, input logic d, input logic we,
                      input logic [31:0] da, input logic [31:0] wd);
    fetch_req = f; data_req = d; data_we = we; data_addr = da; data_wdata = wd;
    #1;
    chk("R2/R3/R8 mem_en", {31'b0, mem_en}, {31'b0, f | d});
    chk("R4 stall", {31'b0, stall}, {31'b0, f & d});
    if (d) begin
      chk("R2 mem_addr", mem_addr, da);
      chk("R2 mem_we", {31'b0, mem_we}, {31'b0, we});
      if (we) chk("R2 mem_wdata", mem_wdata, wd);
    end else if (f) begin
      chk("R3 mem_addr", mem_addr, e_pc);
      chk("R3 mem_we", {31'b0, mem_we}, 32'd0);
    end
    @(posedge clk);
    // Model update, old values on the right.
    if (e_fpend) begin e_valid = 1; e_ifid_pc = e_fpc; e_ifid_instr = e_fword; end
    e_new = e_fpend;
    e_bub = e_bpend;
    e_rvalid = d & ~we;
    if (d & ~we) e_dword = tmem[da[7:2]];
    e_fpend = f & ~d;
    e_fpc = e_pc;
    e_fword = tmem[e_pc[7:2]];
    e_bpend = f & d;
    if (f & ~d) e_pc = e_pc + 4;
    if (f & d) e_cnt = e_cnt + 1;
    @(negedge clk);
    chk("R3/R4/R8 pc", pc, e_pc);
    chk("R7 stall_count", {16'b0, stall_count}, {16'b0, e_cnt});
    chk("R6 bubble", {31'b0, bubble}, {31'b0, e_bub});
    chk("R5 ifid_valid", {31'b0, ifid_valid}, {31'b0, e_valid});
    if (e_valid) begin
      chk("R5/R6 ifid_pc", ifid_pc, e_ifid_pc);
      chk("R5/R6 ifid_instr", ifid_instr, e_ifid_instr);
    end
    chk("R5/R6 idex_instr", idex_instr, e_new ? e_ifid_instr : 32'h0);
    chk("R2/R9 data_rvalid", {31'b0, data_rvalid}, {31'b0, e_rvalid});
    if (e_rvalid) chk("R2 data_rdata", data_rdata, e_dword);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk("R1 pc in reset", pc, 32'h0);
    chk("R1 count in reset", {16'b0, stall_count}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    // R1 first cycle after reset
    chk("R1 pc", pc, 32'h0);
    chk("R1 ifid_valid", {31'b0, ifid_valid}, 32'd0);
    chk("R1 bubble", {31'b0, bubble}, 32'd0);
    chk("R1 data_rvalid", {31'b0, data_rvalid}, 32'd0);
    chk("R1 stall_count", {16'b0, stall_count}, 32'd0);
    chk("R1 idex_instr", idex_instr, 32'h0);

    // Directed: fetch, conflict, fetch, idle, idle (R5, R6 slot timing)
    step(1, 0, 0, 32'h40, 32'h0);
    step(1, 1, 0, 32'h40, 32'h0);
    step(1, 0, 0, 32'h40, 32'h0);
    step(0, 0, 0, 32'h0, 32'h0);
    step(0, 0, 0, 32'h0, 32'h0);

    // Sweep of every 4-cycle pattern of fetch/data/we (R2..R9)
    for (int s = 0; s < 4096; s++) begin
      for (int k = 0; k < 4; k++) begin
        logic [2:0] b;
        b = 3'((s >> (3 * k)) & 7);
        step(b[0], b[1], b[2], {24'b0, 6'((s * 5 + k) & 63), 2'b00},
             32'hD000_0000 | (s << 2) | k);
      end
    end
    step(0, 0, 0, 32'h0, 32'h0);
    step(0, 0, 0, 32'h0, 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule